// File: doc/BRIEF.md
# Byte-Programmable Nonvolatile Array with Poll-Able Write Status

This block is a synthesizable behavioural model of two small nonvolatile byte arrays that share one clock. The first bank behaves like an EEPROM. Each byte write erases the location by itself and then programs it. The second bank behaves like a flash. It is organised in 16-bit words, with a select bit that picks the low or the high byte, and it has no erase step of its own. A programming cycle can therefore only clear bits. The phase durations are set in clock cycles by parameters, so a write takes a known, fixed number of cycles.

While a write is in flight, a read of the location being written does not return the stored byte. It returns a marker that depends on the phase. The EEPROM bank gives 0x00 while it erases and 0xFF while it programs. The flash bank gives 0xFF for the whole cycle. A programmer can therefore poll the target address until the new value appears, or it can watch the per-bank busy flag. A chip-erase request fills both arrays with 0xFF in one cycle.

The EEPROM bank moves through the states EE_IDLE, EE_ERASE and EE_PROG:
- EE_IDLE goes to EE_ERASE when a write is requested.
- EE_ERASE goes to EE_PROG when the erase count expires.
- EE_PROG goes back to EE_IDLE, committing the byte, when the program count expires.

The flash bank moves through the states FL_IDLE and FL_PROG:
- FL_IDLE goes to FL_PROG when a write is requested.
- FL_PROG goes back to FL_IDLE, committing the byte, when its count expires.

Top module: `nvm_poll_model`

## Requirements
- R1: After reset both busy outputs are low, every location of both banks holds 0xFF, and both read outputs show 0xFF.
- R2: Read data is registered. The byte for the address presented in one cycle appears on the read output in the next cycle. An EEPROM write accepted while idle raises `ee_busy` from the following cycle. `ee_busy` stays high for ERASE_CYC+WRITE_CYC cycles and then falls.
- R3: During the first ERASE_CYC cycles of an EEPROM write, reading the target address returns 0x00.
- R4: During the following WRITE_CYC cycles, reading the target address returns 0xFF.
- R5: Once an EEPROM write completes, the target reads back exactly the new byte, whatever the location held before.
- R6: While either bank is busy, reads of any other location in that bank return the stored data.
- R7: A write request to a bank whose busy flag is high is ignored and changes no location.
- R8: A flash write holds `fl_busy` high for FL_PROG_CYC cycles. During that time, reading the target byte returns 0xFF.
- R9: A completed flash write leaves the target byte equal to the old byte ANDed with the new byte.
- R10: In the flash bank, `fl_hi` = 0 selects the low byte of the word and `fl_hi` = 1 selects the high byte. A write to one half never alters the other half.
- R11: A chip erase requested while both banks are idle sets every location of both banks to 0xFF. A chip erase requested while either bank is busy is ignored.
- R12: When a chip erase and a write request arrive in the same cycle with both banks idle, the erase is carried out and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_erase | input | 1 | Request to fill both arrays with 0xFF |
| ee_wr | input | 1 | EEPROM bank write request |
| ee_addr | input | EE_ADDR_W | EEPROM byte address for reads and writes |
| ee_wdata | input | 8 | EEPROM write byte |
| ee_rdata | output | 8 | EEPROM read byte, one cycle after the address |
| ee_busy | output | 1 | EEPROM write in progress |
| fl_wr | input | 1 | Flash bank write request |
| fl_addr | input | FL_ADDR_W | Flash word address |
| fl_hi | input | 1 | Flash byte select (0 low, 1 high) |
| fl_wdata | input | 8 | Flash write byte |
| fl_rdata | output | 8 | Flash read byte, one cycle after the address |
| fl_busy | output | 1 | Flash write in progress |

## Verification
Several functions can fall in the same cycle:
- A chip erase and a write request to either bank can collide.
- A chip erase can arrive while a write is still running.

The bench provokes both cases. For the first, it raises `chip_erase`, `ee_wr` and `fl_wr` on one clock edge and checks that no busy flag rises and that the targets read 0xFF. For the second, it pulses `chip_erase` in the middle of an EEPROM write and checks that previously programmed bytes survive and that the write completes.

Reads of neighbouring addresses are also interleaved with a running write. The bench judges them against its own shadow copy of the arrays.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        EE_IDLE  = 2'd0,
        EE_ERASE = 2'd1,
        EE_PROG  = 2'd2
    } ee_state_t;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_PROG = 1'b1
    } fl_state_t;

    localparam logic [7:0] BLANK_BYTE  = 8'hFF;
    localparam logic [7:0] ERASE_MARK  = 8'h00;
    localparam logic [7:0] PROG_MARK   = 8'hFF;

endpackage

// File: rtl/nvm_ee_bank.sv
module nvm_ee_bank
    import nvm_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int ERASE_CYC = 4,
    parameter int WRITE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int MAXC  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    ee_state_t         state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic              commit;
    logic [7:0]        rd_nx;
    logic [7:0]        mem [DEPTH];

    // Next state and phase counter
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        commit   = 1'b0;
        unique case (state)
            EE_IDLE: begin
                if (wr_req) begin
                    state_nx = EE_ERASE;
                    cnt_nx   = CNT_W'(ERASE_CYC - 1);
                end
            end
            EE_ERASE: begin
                if (cnt == '0) begin
                    state_nx = EE_PROG;
                    cnt_nx   = CNT_W'(WRITE_CYC - 1);
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            EE_PROG: begin
                if (cnt == '0) begin
                    state_nx = EE_IDLE;
                    commit   = 1'b1;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: state_nx = EE_IDLE;
        endcase
    end

    // Outputs: busy flag and phase-dependent readback
    always_comb begin
        busy = (state != EE_IDLE);
        if (busy && (addr == tgt_addr))
            rd_nx = (state == EE_ERASE) ? ERASE_MARK : PROG_MARK;
        else
            rd_nx = mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= EE_IDLE;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            rdata    <= BLANK_BYTE;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            rdata <= rd_nx;
            if (state == EE_IDLE && wr_req) begin
                tgt_addr <= addr;
                tgt_data <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
        end else if (wipe) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
        end else if (commit) begin
            mem[tgt_addr] <= tgt_data;
        end
    end

endmodule

// File: rtl/nvm_fl_bank.sv
module nvm_fl_bank
    import nvm_pkg::*;
#(
    parameter int WADDR_W  = 5,
    parameter int PROG_CYC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wipe,
    input  logic               wr_req,
    input  logic [WADDR_W-1:0] addr,
    input  logic               hi,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               busy
);
    localparam int DEPTH = 1 << WADDR_W;
    localparam int CNT_W = $clog2(PROG_CYC + 1);

    fl_state_t          state, state_nx;
    logic [CNT_W-1:0]   cnt, cnt_nx;
    logic [WADDR_W-1:0] tgt_addr;
    logic               tgt_hi;
    logic [7:0]         tgt_data;
    logic               commit;
    logic [7:0]         rd_nx;
    logic [1:0][7:0]    mem [DEPTH];

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        commit   = 1'b0;
        unique case (state)
            FL_IDLE: begin
                if (wr_req) begin
                    state_nx = FL_PROG;
                    cnt_nx   = CNT_W'(PROG_CYC - 1);
                end
            end
            FL_PROG: begin
                if (cnt == '0) begin
                    state_nx = FL_IDLE;
                    commit   = 1'b1;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: state_nx = FL_IDLE;
        endcase
    end

    always_comb begin
        busy = (state == FL_PROG);
        if (busy && (addr == tgt_addr) && (hi == tgt_hi))
            rd_nx = PROG_MARK;
        else
            rd_nx = mem[addr][hi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= FL_IDLE;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_hi   <= 1'b0;
            tgt_data <= '0;
            rdata    <= BLANK_BYTE;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            rdata <= rd_nx;
            if (state == FL_IDLE && wr_req) begin
                tgt_addr <= addr;
                tgt_hi   <= hi;
                tgt_data <= wdata;
            end
        end
    end

    // Programming can only pull bits low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= {BLANK_BYTE, BLANK_BYTE};
        end else if (wipe) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= {BLANK_BYTE, BLANK_BYTE};
        end else if (commit) begin
            mem[tgt_addr][tgt_hi] <= mem[tgt_addr][tgt_hi] & tgt_data;
        end
    end

endmodule

// File: rtl/nvm_poll_model.sv
module nvm_poll_model #(
    parameter int EE_ADDR_W   = 5,
    parameter int FL_ADDR_W   = 5,
    parameter int ERASE_CYC   = 4,
    parameter int WRITE_CYC   = 3,
    parameter int FL_PROG_CYC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_erase,
    input  logic                 ee_wr,
    input  logic [EE_ADDR_W-1:0] ee_addr,
    input  logic [7:0]           ee_wdata,
    output logic [7:0]           ee_rdata,
    output logic                 ee_busy,
    input  logic                 fl_wr,
    input  logic [FL_ADDR_W-1:0] fl_addr,
    input  logic                 fl_hi,
    input  logic [7:0]           fl_wdata,
    output logic [7:0]           fl_rdata,
    output logic                 fl_busy
);
    logic erase_go;
    logic ee_req;
    logic fl_req;

    // Erase only when both banks are idle; it then shadows any write request
    assign erase_go = chip_erase && !ee_busy && !fl_busy;
    assign ee_req   = ee_wr && !erase_go;
    assign fl_req   = fl_wr && !erase_go;

    nvm_ee_bank #(
        .ADDR_W    (EE_ADDR_W),
        .ERASE_CYC (ERASE_CYC),
        .WRITE_CYC (WRITE_CYC)
    ) u_ee (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (erase_go),
        .wr_req (ee_req),
        .addr   (ee_addr),
        .wdata  (ee_wdata),
        .rdata  (ee_rdata),
        .busy   (ee_busy)
    );

    nvm_fl_bank #(
        .WADDR_W  (FL_ADDR_W),
        .PROG_CYC (FL_PROG_CYC)
    ) u_fl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (erase_go),
        .wr_req (fl_req),
        .addr   (fl_addr),
        .hi     (fl_hi),
        .wdata  (fl_wdata),
        .rdata  (fl_rdata),
        .busy   (fl_busy)
    );

endmodule

// File: rtl/nvm_poll_sva.sv
module nvm_poll_sva #(
    parameter int EE_ADDR_W   = 5,
    parameter int FL_ADDR_W   = 5,
    parameter int ERASE_CYC   = 4,
    parameter int WRITE_CYC   = 3,
    parameter int FL_PROG_CYC = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chip_erase,
    input logic                 ee_wr,
    input logic [EE_ADDR_W-1:0] ee_addr,
    input logic [7:0]           ee_wdata,
    input logic [7:0]           ee_rdata,
    input logic                 ee_busy,
    input logic                 fl_wr,
    input logic [FL_ADDR_W-1:0] fl_addr,
    input logic                 fl_hi,
    input logic [7:0]           fl_wdata,
    input logic [7:0]           fl_rdata,
    input logic                 fl_busy
);
    logic                 idle_erase;
    logic [EE_ADDR_W-1:0] ee_tgt;
    logic [FL_ADDR_W-1:0] fl_tgt;
    logic                 fl_tgt_hi;

    assign idle_erase = chip_erase && !ee_busy && !fl_busy;

    // Track accepted targets from the port side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ee_tgt    <= '0;
            fl_tgt    <= '0;
            fl_tgt_hi <= 1'b0;
        end else begin
            if (ee_wr && !ee_busy && !idle_erase) ee_tgt <= ee_addr;
            if (fl_wr && !fl_busy && !idle_erase) begin
                fl_tgt    <= fl_addr;
                fl_tgt_hi <= fl_hi;
            end
        end
    end

    p_start_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_busy) |-> $past(ee_wr));

    p_ee_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ee_busy) && $past(ee_addr) == ee_tgt) |-> (ee_rdata == 8'h00 || ee_rdata == 8'hFF));

    p_fl_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fl_busy) && $past(fl_addr) == fl_tgt && $past(fl_hi) == fl_tgt_hi) |-> fl_rdata == 8'hFF);

    p_erase_fills_r11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_erase |=> ##1 (ee_rdata == 8'hFF && fl_rdata == 8'hFF));

    p_erase_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        idle_erase |=> (!ee_busy && !fl_busy));

endmodule

bind nvm_poll_model nvm_poll_sva #(
    .EE_ADDR_W   (EE_ADDR_W),
    .FL_ADDR_W   (FL_ADDR_W),
    .ERASE_CYC   (ERASE_CYC),
    .WRITE_CYC   (WRITE_CYC),
    .FL_PROG_CYC (FL_PROG_CYC)
) u_sva (.*);

// File: tb/nvm_poll_model_bench.sv
module nvm_poll_model_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EA = 5;
    localparam int FA = 5;
    localparam int EC = 4;
    localparam int WC = 3;
    localparam int FC = 6;

    // Vector: {bank(1: flash), hi, addr[4:0], data[7:0]} in 15 bits
    localparam int NVEC = 8;
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 5'd3,  8'hA5},
        {1'b0, 1'b0, 5'd3,  8'h5A},
        {1'b0, 1'b0, 5'd31, 8'h3C},
        {1'b0, 1'b0, 5'd0,  8'h01},
        {1'b1, 1'b0, 5'd2,  8'hF0},
        {1'b1, 1'b0, 5'd2,  8'h3C},
        {1'b1, 1'b1, 5'd2,  8'h0F},
        {1'b1, 1'b1, 5'd31, 8'hAA}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_erase = 1'b0;
    logic          ee_wr = 1'b0;
    logic [EA-1:0] ee_addr = '0;
    logic [7:0]    ee_wdata = '0;
    logic [7:0]    ee_rdata;
    logic          ee_busy;
    logic          fl_wr = 1'b0;
    logic [FA-1:0] fl_addr = '0;
    logic          fl_hi = 1'b0;
    logic [7:0]    fl_wdata = '0;
    logic [7:0]    fl_rdata;
    logic          fl_busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ee_sh [32];
    logic [7:0] fl_sh [32][2];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_poll_model #(
        .EE_ADDR_W(EA), .FL_ADDR_W(FA), .ERASE_CYC(EC), .WRITE_CYC(WC), .FL_PROG_CYC(FC)
    ) u_nvm_poll_model (
        .clk(clk), .rst_n(rst_n), .chip_erase(chip_erase),
        .ee_wr(ee_wr), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_rdata(ee_rdata), .ee_busy(ee_busy),
        .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_hi(fl_hi), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_busy(fl_busy)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ee_read(input logic [EA-1:0] a, input logic [7:0] exp, input string tag);
        ee_addr = a;
        step();
        chk(tag, ee_rdata, exp);
    endtask

    task automatic fl_read(input logic [FA-1:0] a, input logic h, input logic [7:0] exp, input string tag);
        fl_addr = a;
        fl_hi = h;
        step();
        chk(tag, fl_rdata, exp);
    endtask

    task automatic ee_write_watch(input logic [EA-1:0] a, input logic [7:0] d);
        ee_wr = 1'b1;
        ee_addr = a;
        ee_wdata = d;
        step();
        ee_wr = 1'b0;
        chk("R2 busy raised", {7'd0, ee_busy}, 8'd1);
        for (int k = 1; k <= EC; k++) begin
            step();
            chk("R3 erase marker", ee_rdata, 8'h00);
        end
        for (int k = 1; k <= WC; k++) begin
            step();
            chk("R4 program marker", ee_rdata, 8'hFF);
            chk("R2 busy span", {7'd0, ee_busy}, (k == WC) ? 8'd0 : 8'd1);
        end
        step();
        ee_sh[a] = d;
        chk("R5 final value", ee_rdata, d);
    endtask

    task automatic fl_write_watch(input logic [FA-1:0] a, input logic h, input logic [7:0] d);
        fl_wr = 1'b1;
        fl_addr = a;
        fl_hi = h;
        fl_wdata = d;
        step();
        fl_wr = 1'b0;
        for (int k = 1; k <= FC; k++) begin
            step();
            chk("R8 flash marker", fl_rdata, 8'hFF);
            chk("R8 flash busy", {7'd0, fl_busy}, (k == FC) ? 8'd0 : 8'd1);
        end
        step();
        fl_sh[a][h] = fl_sh[a][h] & d;
        chk("R9 AND result", fl_rdata, fl_sh[a][h]);
        fl_read(a, ~h, fl_sh[a][~h], "R10 other half intact");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            ee_sh[i] = 8'hFF;
            fl_sh[i][0] = 8'hFF;
            fl_sh[i][1] = 8'hFF;
        end
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 ee_busy", {7'd0, ee_busy}, 8'd0);
        chk("R1 fl_busy", {7'd0, fl_busy}, 8'd0);
        ee_read(5'd9, 8'hFF, "R1 ee blank");
        fl_read(5'd9, 1'b1, 8'hFF, "R1 fl blank");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][14])
                fl_write_watch(VEC[i][12:8], VEC[i][13], VEC[i][7:0]);
            else
                ee_write_watch(VEC[i][12:8], VEC[i][7:0]);
        end

        // R6 and R7: other-address reads and a second request while busy
        ee_wr = 1'b1; ee_addr = 5'd5; ee_wdata = 8'h77;
        step();
        ee_wr = 1'b0;
        ee_read(5'd3, ee_sh[3], "R6 other addr during busy");
        ee_wr = 1'b1; ee_wdata = 8'h11; ee_addr = 5'd6;
        step();
        ee_wr = 1'b0;
        chk("R6 other addr during busy", ee_rdata, 8'hFF);
        ee_read(5'd31, ee_sh[31], "R6 other addr during busy");
        while (ee_busy) step();
        ee_sh[5] = 8'h77;
        ee_read(5'd5, 8'h77, "R7 first write kept");
        ee_read(5'd6, 8'hFF, "R7 busy write ignored");

        // R10/R6 flash: other half readable during busy, busy write ignored
        fl_wr = 1'b1; fl_addr = 5'd4; fl_hi = 1'b1; fl_wdata = 8'h81;
        step();
        fl_wr = 1'b1; fl_addr = 5'd2; fl_hi = 1'b0; fl_wdata = 8'h00;
        step();
        fl_wr = 1'b0;
        fl_read(5'd4, 1'b0, 8'hFF, "R10 low half during high write");
        fl_read(5'd2, 1'b0, fl_sh[2][0], "R7 flash busy write ignored");
        while (fl_busy) step();
        fl_sh[4][1] = 8'h81;
        fl_read(5'd4, 1'b1, 8'h81, "R10 high half written");
        fl_read(5'd2, 1'b0, fl_sh[2][0], "R7 flash busy write ignored");

        // R11: erase while busy is ignored
        ee_wr = 1'b1; ee_addr = 5'd7; ee_wdata = 8'h42;
        step();
        ee_wr = 1'b0;
        chip_erase = 1'b1;
        step();
        chip_erase = 1'b0;
        while (ee_busy) step();
        ee_sh[7] = 8'h42;
        ee_read(5'd5, 8'h77, "R11 erase during busy ignored");
        ee_read(5'd7, 8'h42, "R11 write survives erase attempt");

        // R11: erase while idle fills both banks
        chip_erase = 1'b1;
        step();
        chip_erase = 1'b0;
        ee_read(5'd5, 8'hFF, "R11 ee erased");
        fl_read(5'd4, 1'b1, 8'hFF, "R11 fl erased");
        fl_read(5'd2, 1'b0, 8'hFF, "R11 fl erased");

        // R12: erase and writes on the same edge
        ee_read(5'd7, 8'hFF, "R11 ee erased");
        chip_erase = 1'b1;
        ee_wr = 1'b1; ee_addr = 5'd8; ee_wdata = 8'h12;
        fl_wr = 1'b1; fl_addr = 5'd8; fl_hi = 1'b0; fl_wdata = 8'h34;
        step();
        chip_erase = 1'b0; ee_wr = 1'b0; fl_wr = 1'b0;
        chk("R12 ee write dropped", {7'd0, ee_busy}, 8'd0);
        chk("R12 fl write dropped", {7'd0, fl_busy}, 8'd0);
        repeat (EC + WC + 2) step();
        ee_read(5'd8, 8'hFF, "R12 ee target blank");
        fl_read(5'd8, 1'b0, 8'hFF, "R12 fl target blank");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule